// File: doc/BRIEF.md
# Synchronized Serial Command Framer

This block turns one command request into the byte sequence that a serial-attached USB file-manager controller expects, and gathers the bytes the controller sends back. A request carries an opcode, up to `MAX_PARAMS` parameter bytes with a count, and the number of response bytes to collect. The request is handed over with a valid/ready handshake. The block then emits a fixed two-byte sync preamble, the opcode and the parameters on a byte-wide transmit stream. That stream feeds an external 8N1 UART, which runs at 9600 baud from a 48 MHz clock in the intended system.

If a response is expected, bytes from the UART receive stream are passed out one at a time with a strobe. A receive timeout measured in system-clock cycles guards the response phase. A single-cycle done pulse closes every transaction, and an error flag shows whether that transaction ended by timeout. The bit-level UART and the meaning of the commands are outside this block.

Top module: `cmd_framer`

## Requirements
- R1: After reset, req_ready is 1 and tx_valid, rsp_valid, done and timeout_err are 0.
- R2: A request is taken only when req_ready is high, which is only while idle. Once taken, the frame is sent as captured, and changes to the request inputs while busy have no effect on it.
- R3: Every frame starts with byte 0x57, then byte 0xAB, then the opcode.
- R4: Parameter bytes follow the opcode, taken from req_params least-significant byte first (bits 7:0, then 15:8, and so on). A 16-bit value therefore goes low byte first.
- R5: A byte moves only on a cycle with tx_valid and tx_ready both high. While tx_ready is low, tx_valid stays high and tx_data stays stable.
- R6: A parameter count of 0 skips the parameter phase, and a response count of 0 skips the response phase.
- R7: In the response phase, each rx_valid byte appears in the same cycle on rsp_data with rsp_valid, until req_nresp bytes are seen. rx bytes outside that phase are ignored, and rsp_valid stays 0 for them.
- R8: If no rx byte arrives within TIMEOUT_CYCLES cycles of entering the response phase or of the previous byte, the transaction ends with timeout_err set to 1. A byte that arrives in the last cycle of the window is accepted and restarts the window. timeout_err stays set until the next request is taken.
- R9: done is high for exactly one cycle. That cycle follows the last transmit handshake (no response) or the last response byte or the timeout, and req_ready is high again on the next cycle.
- R10: A request with opcode 0x36, one parameter 0x01 and no response produces exactly the stream 0x57, 0xAB, 0x36, 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_opcode | input | 8 | Command code |
| req_nparam | input | $clog2(MAX_PARAMS+1) | Number of parameter bytes |
| req_params | input | MAX_PARAMS*8 | Parameter bytes, byte 0 in bits 7:0 |
| req_nresp | input | RESP_W | Number of response bytes to collect |
| tx_data | output | 8 | Byte to the UART transmitter |
| tx_valid | output | 1 | tx_data is valid |
| tx_ready | input | 1 | Transmitter takes the byte |
| rx_data | input | 8 | Byte from the UART receiver |
| rx_valid | input | 1 | rx_data is valid for one cycle |
| rsp_data | output | 8 | Response byte |
| rsp_valid | output | 1 | Response byte strobe |
| done | output | 1 | One-cycle end-of-transaction pulse |
| timeout_err | output | 1 | Last transaction ended by receive timeout |

## Verification
Byte arrival and timeout expiry can fall in the same cycle. This happens when a response byte turns up on the exact cycle on which the wait window runs out. The bench provokes it by holding rx_valid low for TIMEOUT_CYCLES-1 response cycles and then presenting a byte, and it also runs a gap one cycle longer. The cycle model predicts that the byte wins and the window restarts in the first case, and that the transaction aborts with timeout_err in the second, and both are checked against done, rsp_valid and timeout_err cycle by cycle.

// File: rtl/cmdf_pkg.sv
// Shared constants and state type for the command framer.
package cmdf_pkg;
    localparam logic [7:0] PREAMBLE_0 = 8'h57;
    localparam logic [7:0] PREAMBLE_1 = 8'hAB;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE0,
        ST_PRE1,
        ST_OPCODE,
        ST_PARAM,
        ST_RESP,
        ST_DONE
    } frm_state_e;
endpackage

// File: rtl/cmdf_tx_sel.sv
// Transmit byte selector: picks the byte for the current frame position.
// Assumes idx < number of captured parameters while in ST_PARAM.
module cmdf_tx_sel
    import cmdf_pkg::*;
#(
    parameter int MAX_PARAMS = 4,
    parameter int CNT_W      = 3
) (
    input  frm_state_e                state,
    input  logic [7:0]                opcode,
    input  logic [MAX_PARAMS*8-1:0]   params,
    input  logic [CNT_W-1:0]          idx,
    output logic                      tx_valid,
    output logic [7:0]                tx_byte
);
    logic [7:0] pbyte [MAX_PARAMS];
    logic [7:0] psel;

    // Slice the flat parameter vector into bytes, byte 0 lowest.
    for (genvar g = 0; g < MAX_PARAMS; g++) begin : g_slice
        assign pbyte[g] = params[g*8 +: 8];
    end

    // Select the parameter byte addressed by idx.
    always_comb begin
        psel = 8'h00;
        for (int i = 0; i < MAX_PARAMS; i++) begin
            if (idx == CNT_W'(i)) psel = pbyte[i];
        end
    end

    // Choose the outgoing byte from the frame position.
    always_comb begin
        tx_valid = 1'b1;
        unique case (state)
            ST_PRE0:   tx_byte = PREAMBLE_0;
            ST_PRE1:   tx_byte = PREAMBLE_1;
            ST_OPCODE: tx_byte = opcode;
            ST_PARAM:  tx_byte = psel;
            default: begin
                tx_valid = 1'b0;
                tx_byte  = 8'h00;
            end
        endcase
    end
endmodule

// File: rtl/cmdf_resp_track.sv
// Response tracker: counts remaining response bytes and times the gap
// between them. Assumes load is pulsed when a request is taken and that
// active is high only during the response phase.
module cmdf_resp_track #(
    parameter int RESP_W         = 8,
    parameter int TIMEOUT_CYCLES = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [RESP_W-1:0] nresp,
    input  logic              active,
    input  logic              rx_valid,
    output logic              last_byte,
    output logic              expire
);
    localparam int TO_W = (TIMEOUT_CYCLES > 1) ? $clog2(TIMEOUT_CYCLES) : 1;

    logic [RESP_W-1:0] left_q;
    logic [TO_W-1:0]   wait_q;

    // Remaining response byte count.
    always_ff @(posedge clk) begin
        if (!rst_n)                  left_q <= '0;
        else if (load)               left_q <= nresp;
        else if (active && rx_valid) left_q <= left_q - 1'b1;
    end

    // Idle-cycle counter, cleared outside the phase and on each byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                    wait_q <= '0;
        else if (!active || rx_valid)  wait_q <= '0;
        else if (!expire)              wait_q <= wait_q + 1'b1;
    end

    assign last_byte = active && rx_valid && (left_q == RESP_W'(1));
    assign expire    = active && !rx_valid && (wait_q == TO_W'(TIMEOUT_CYCLES - 1));
endmodule

// File: rtl/cmd_framer.sv
// Command framer top: captures a request, sends preamble, opcode and
// parameters over a byte stream, then collects response bytes with a
// timeout. Assumes req_nparam <= MAX_PARAMS and a byte-level UART outside.
module cmd_framer
    import cmdf_pkg::*;
#(
    parameter int MAX_PARAMS     = 4,
    parameter int RESP_W         = 8,
    parameter int TIMEOUT_CYCLES = 100000,
    localparam int PCNT_W        = $clog2(MAX_PARAMS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [7:0]              req_opcode,
    input  logic [PCNT_W-1:0]       req_nparam,
    input  logic [MAX_PARAMS*8-1:0] req_params,
    input  logic [RESP_W-1:0]       req_nresp,
    output logic [7:0]              tx_data,
    output logic                    tx_valid,
    input  logic                    tx_ready,
    input  logic [7:0]              rx_data,
    input  logic                    rx_valid,
    output logic [7:0]              rsp_data,
    output logic                    rsp_valid,
    output logic                    done,
    output logic                    timeout_err
);
    frm_state_e              state_q, state_d;
    logic [7:0]              op_q;
    logic [PCNT_W-1:0]       np_q;
    logic [MAX_PARAMS*8-1:0] par_q;
    logic                    nr_zero_q;
    logic [PCNT_W-1:0]       idx_q;
    logic [PCNT_W-1:0]       idx_nxt;
    logic                    err_q;
    logic                    accept, tx_fire, in_resp, last_byte, expire;
    frm_state_e              after_tx;

    assign accept    = (state_q == ST_IDLE) && req_valid;
    assign tx_fire   = tx_valid && tx_ready;
    assign in_resp   = (state_q == ST_RESP);
    assign idx_nxt   = idx_q + 1'b1;
    assign after_tx  = nr_zero_q ? ST_DONE : ST_RESP;

    cmdf_tx_sel #(.MAX_PARAMS(MAX_PARAMS), .CNT_W(PCNT_W)) u_sel (
        .state    (state_q),
        .opcode   (op_q),
        .params   (par_q),
        .idx      (idx_q),
        .tx_valid (tx_valid),
        .tx_byte  (tx_data)
    );

    cmdf_resp_track #(.RESP_W(RESP_W), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .nresp     (req_nresp),
        .active    (in_resp),
        .rx_valid  (rx_valid),
        .last_byte (last_byte),
        .expire    (expire)
    );

    // Next frame position.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_PRE0;
            ST_PRE0:   if (tx_fire) state_d = ST_PRE1;
            ST_PRE1:   if (tx_fire) state_d = ST_OPCODE;
            ST_OPCODE: if (tx_fire) state_d = (np_q != '0) ? ST_PARAM : after_tx;
            ST_PARAM:  if (tx_fire && idx_nxt == np_q) state_d = after_tx;
            ST_RESP:   if (last_byte || expire) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Lock the request fields when it is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q      <= '0;
            np_q      <= '0;
            par_q     <= '0;
            nr_zero_q <= 1'b1;
        end else if (accept) begin
            op_q      <= req_opcode;
            np_q      <= req_nparam;
            par_q     <= req_params;
            nr_zero_q <= (req_nresp == '0);
        end
    end

    // Parameter index, advanced on each parameter handshake.
    always_ff @(posedge clk) begin
        if (!rst_n)                            idx_q <= '0;
        else if (accept)                       idx_q <= '0;
        else if (tx_fire && state_q == ST_PARAM) idx_q <= idx_nxt;
    end

    // Timeout flag, held until the next request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)      err_q <= 1'b0;
        else if (accept) err_q <= 1'b0;
        else if (expire) err_q <= 1'b1;
    end

    assign req_ready   = (state_q == ST_IDLE);
    assign rsp_valid   = in_resp && rx_valid;
    assign rsp_data    = rsp_valid ? rx_data : 8'h00;
    assign done        = (state_q == ST_DONE);
    assign timeout_err = err_q;
endmodule

// File: rtl/cmd_framer_chk.sv
// Port-level checker for cmd_framer, attached by bind below.
module cmd_framer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic [7:0] tx_data,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] rx_data,
    input logic       rx_valid,
    input logic [7:0] rsp_data,
    input logic       rsp_valid,
    input logic       done,
    input logic       timeout_err
);
    // R5
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

    // R2
    ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !tx_valid && !rsp_valid && !done);

    // R3
    preamble_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> tx_valid && tx_data == 8'h57);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && req_ready);

    // R7
    rsp_from_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rx_valid && rsp_data == rx_data);

    // R8
    err_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> done);
endmodule

bind cmd_framer cmd_framer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .tx_data     (tx_data),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .rx_data     (rx_data),
    .rx_valid    (rx_valid),
    .rsp_data    (rsp_data),
    .rsp_valid   (rsp_valid),
    .done        (done),
    .timeout_err (timeout_err)
);

// File: tb/cmd_framer_test.sv
`timescale 1ns/1ps
module cmd_framer_test;
    localparam int MAXP = 4;
    localparam int RW   = 8;
    localparam int TO   = 20;
    localparam int PW   = $clog2(MAXP + 1);

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [7:0]      req_opcode = '0;
    logic [PW-1:0]   req_nparam = '0;
    logic [MAXP*8-1:0] req_params = '0;
    logic [RW-1:0]   req_nresp = '0;
    logic [7:0]      tx_data;
    logic            tx_valid;
    logic            tx_ready = 1'b1;
    logic [7:0]      rx_data = '0;
    logic            rx_valid = 1'b0;
    logic [7:0]      rsp_data;
    logic            rsp_valid;
    logic            done;
    logic            timeout_err;

    cmd_framer #(.MAX_PARAMS(MAXP), .RESP_W(RW), .TIMEOUT_CYCLES(TO)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_opcode(req_opcode), .req_nparam(req_nparam), .req_params(req_params),
        .req_nresp(req_nresp), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
        .rsp_data(rsp_data), .rsp_valid(rsp_valid), .done(done),
        .timeout_err(timeout_err)
    );

    int compared = 0;
    int mismatched = 0;

    // Behavioural reference model state.
    bit         m_idle = 1, m_resp = 0, m_fin = 0, m_err = 0, m_accepted = 0;
    logic [7:0] txq[$];
    int         m_left = 0, m_wcnt = 0;
    logic [7:0] tx_log[$];
    logic [7:0] rsp_log[$];
    bit         stall = 0;
    int         cyc = 0;
    int         done_cnt = 0;

    task automatic check(bit ok, string req, string what, int act, int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        bit bad;
        bit e_txv;
        tx_ready = stall ? (cyc % 3 != 0) : 1'b1;
        cyc++;
        #1;
        e_txv = !m_idle && !m_fin && !m_resp && txq.size() > 0;
        bad = 0;
        compared++;
        if (req_ready !== m_idle) begin
            bad = 1; $display("FAIL R2 req_ready actual=%0h expected=%0h", req_ready, m_idle);
        end
        if (tx_valid !== e_txv) begin
            bad = 1; $display("FAIL R5 tx_valid actual=%0h expected=%0h", tx_valid, e_txv);
        end else if (e_txv && tx_data !== txq[0]) begin
            bad = 1; $display("FAIL R3 tx_data actual=%0h expected=%0h", tx_data, txq[0]);
        end
        if (rsp_valid !== (m_resp && rx_valid)) begin
            bad = 1; $display("FAIL R7 rsp_valid actual=%0h expected=%0h", rsp_valid, m_resp && rx_valid);
        end else if (rsp_valid && rsp_data !== rx_data) begin
            bad = 1; $display("FAIL R7 rsp_data actual=%0h expected=%0h", rsp_data, rx_data);
        end
        if (done !== m_fin) begin
            bad = 1; $display("FAIL R9 done actual=%0h expected=%0h", done, m_fin);
        end
        if (timeout_err !== m_err) begin
            bad = 1; $display("FAIL R8 timeout_err actual=%0h expected=%0h", timeout_err, m_err);
        end
        if (bad) mismatched++;
        if (tx_valid && tx_ready) tx_log.push_back(tx_data);
        if (rsp_valid) rsp_log.push_back(rsp_data);
        if (done) done_cnt++;
        @(posedge clk);
        if (m_fin) begin
            m_fin = 0; m_idle = 1;
        end else if (m_idle) begin
            if (req_valid) begin
                m_idle = 0; m_err = 0; m_accepted = 1;
                txq = {8'h57, 8'hAB, req_opcode};
                for (int i = 0; i < int'(req_nparam); i++) txq.push_back(req_params[i*8 +: 8]);
                m_left = int'(req_nresp);
            end
        end else if (m_resp) begin
            if (rx_valid) begin
                m_left--; m_wcnt = 0;
                if (m_left == 0) begin m_resp = 0; m_fin = 1; end
            end else if (m_wcnt == TO - 1) begin
                m_err = 1; m_resp = 0; m_fin = 1;
            end else m_wcnt++;
        end else if (tx_ready) begin
            void'(txq.pop_front());
            if (txq.size() == 0) begin
                if (m_left > 0) begin m_resp = 1; m_wcnt = 0; end
                else m_fin = 1;
            end
        end
        @(negedge clk);
    endtask

    task automatic run_frame(logic [7:0] op, int np, logic [31:0] par, int nr,
                             int gap, bit noise, bit hold);
        int w = 0;
        int k = 0;
        tx_log.delete(); rsp_log.delete();
        req_opcode = op; req_nparam = PW'(np); req_params = par; req_nresp = RW'(nr);
        req_valid = 1'b1; m_accepted = 0;
        while (!m_accepted) step();
        if (hold) begin req_opcode = 8'hEE; req_params = '1; end
        else req_valid = 1'b0;
        while (!m_idle) begin
            if (hold && m_fin) req_valid = 1'b0;
            if (m_resp) begin
                if (w == gap) begin rx_valid = 1'b1; rx_data = 8'hC0 + 8'(k); k++; w = 0; end
                else begin rx_valid = 1'b0; w++; end
            end else begin
                rx_valid = noise; rx_data = 8'h5A;
            end
            step();
        end
        rx_valid = 1'b0; req_valid = 1'b0;
    endtask

    task automatic expect_tx(string req, logic [7:0] op, int np, logic [31:0] par);
        logic [7:0] exp[$];
        exp = {8'h57, 8'hAB, op};
        for (int i = 0; i < np; i++) exp.push_back(par[i*8 +: 8]);
        check(tx_log.size() == exp.size(), req, "stream length", tx_log.size(), exp.size());
        for (int i = 0; i < exp.size() && i < tx_log.size(); i++)
            check(tx_log[i] == exp[i], req, $sformatf("stream byte %0d", i), tx_log[i], exp[i]);
    endtask

    task automatic expect_rsp(string req, int n);
        check(rsp_log.size() == n, req, "response count", rsp_log.size(), n);
        for (int i = 0; i < n && i < rsp_log.size(); i++)
            check(rsp_log[i] == 8'hC0 + 8'(i), req, "response byte", rsp_log[i], 8'hC0 + i);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check(req_ready === 1'b1, "R1", "req_ready", req_ready, 1);
        check(tx_valid === 1'b0, "R1", "tx_valid", tx_valid, 0);
        check(rsp_valid === 1'b0 && done === 1'b0, "R1", "rsp_valid|done", rsp_valid | done, 0);
        check(timeout_err === 1'b0, "R1", "timeout_err", timeout_err, 0);
        @(negedge clk);

        // R10 close-file frame
        run_frame(8'h36, 1, 32'h01, 0, 0, 0, 0);
        expect_tx("R10", 8'h36, 1, 32'h01);
        check(done_cnt == 1, "R9", "done pulses", done_cnt, 1);

        // R4 16-bit parameter low byte first, two responses
        run_frame(8'h3A, 2, 32'h1234, 2, 3, 0, 0);
        expect_tx("R4", 8'h3A, 2, 32'h1234);
        expect_rsp("R7", 2);

        // R6 no parameters, no response; then no parameters, one response
        run_frame(8'h22, 0, 32'h0, 0, 0, 0, 0);
        expect_tx("R6", 8'h22, 0, 32'h0);
        run_frame(8'h27, 0, 32'h0, 1, 1, 0, 0);
        expect_tx("R6", 8'h27, 0, 32'h0);
        expect_rsp("R6", 1);

        // R5 back-pressure on the transmit stream
        stall = 1;
        run_frame(8'h4C, 4, 32'hDDCCBBAA, 0, 0, 0, 0);
        stall = 0;
        expect_tx("R5", 8'h4C, 4, 32'hDDCCBBAA);

        // R2 request inputs changed while busy
        run_frame(8'h36, 1, 32'h01, 0, 0, 0, 1);
        expect_tx("R2", 8'h36, 1, 32'h01);

        // R7 rx noise outside the response phase
        run_frame(8'h30, 1, 32'h05, 1, 2, 1, 0);
        expect_rsp("R7", 1);

        // R8 byte in the last cycle of the window is accepted
        run_frame(8'h31, 0, 32'h0, 2, TO - 1, 0, 0);
        check(timeout_err === 1'b0, "R8", "edge byte err", timeout_err, 0);
        expect_rsp("R8", 2);

        // R8 gap one cycle longer aborts with error
        run_frame(8'h32, 0, 32'h0, 3, TO, 0, 0);
        check(timeout_err === 1'b1, "R8", "timeout flag", timeout_err, 1);
        check(rsp_log.size() == 0, "R8", "responses on timeout", rsp_log.size(), 0);
        run_frame(8'h36, 1, 32'h01, 0, 0, 0, 0);
        check(timeout_err === 1'b0, "R8", "flag cleared", timeout_err, 0);
        check(done_cnt == 10, "R9", "total done pulses", done_cnt, 10);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(8 * 150000);
        mismatched++;
        compared++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule